// File: doc/BRIEF.md
# Instruction Breakpoint Match Unit

This debug block watches the stream of retired instructions. Each retirement arrives as a one-cycle valid strobe that carries the instruction address, a debug context ID, a virtual machine ID and a processor-state tag. Software chooses which of these four tags take part in the comparison and loads a comparison value for each one. A retirement counts as a qualifying match when every selected tag equals its comparison value.

An occurrence counter lets the breakpoint ignore a programmed number of qualifying matches before it fires. When the breakpoint fires, it sets a sticky flag. It can also assert a halt request toward the processor, emit a one-cycle event pulse, or do both.

All configuration and status sit behind a simple word-addressed register read/write port. The port has six registers:
- a control/status word at offset 0;
- the live occurrence count at offset 4;
- the four comparison values at offsets 8, 12, 16 and 20.

Top module: `ibp_match_unit`

## Requirements
- R1: After reset, every register bit is 0 except the support indicator. The control word reads 0x800, the count and all comparison registers read 0, and `halt_req` and `evt_pulse` are low.
- R2: While control bit 0 (enable) is 0, retirements never change the count, never set the triggered flag and never produce a halt request or an event pulse.
- R3: Control bits 5, 7, 8 and 9 select the address, context, VMID and processor-state comparisons respectively. A retirement qualifies only if at least one comparison is selected and every selected tag equals its comparison register. Unselected tags are don't-care.
- R4: Writing n to the count register (offset 4, bits 19:0) makes the breakpoint fire on the (n+1)th qualifying retirement. Each qualifying retirement while the count is nonzero decrements it by one. A qualifying retirement at count 0 fires and leaves the count at 0, so later matches fire again. Non-qualifying retirements leave the count unchanged.
- R5: A read of offset 4 returns the live counter value as it is decremented, not the value last written.
- R6: Control bit 3 is the triggered flag. It becomes 1 on the clock edge that samples a firing retirement and stays 1 until a control write puts 0 in bit 3.
- R7: `halt_req` is high whenever the triggered flag, control bit 1 (halt) and enable are all 1. It therefore rises the cycle after a firing retirement and falls once the flag or the enable is written to 0.
- R8: When control bit 2 (event) is 1, `evt_pulse` is high for exactly the one cycle after each firing retirement. When bit 2 is 0, firing gives no pulse but still sets the flag.
- R9: Control bit 11 always reads 1. Bits 4, 6, 10 and 31:12 of the control word, bits 31:20 of the count register, and offsets with no register all read 0, and writes to them have no effect.
- R10: The comparison registers at offsets 8, 12, 16 and 20 are read/write. Each keeps only its tag width (32, 8, 8 and 2 bits by default) and reads back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not reading |
| iv_valid | input | 1 | One retired instruction this cycle |
| iv_addr | input | 32 | Retired instruction address |
| iv_ctx | input | 8 | Debug context ID tag |
| iv_vmid | input | 8 | Virtual machine ID tag |
| iv_pst | input | 2 | Processor-state tag |
| halt_req | output | 1 | Halt request toward the processor |
| evt_pulse | output | 1 | One-cycle trigger event |

## Verification
The bench sweeps all sixteen criterion-select combinations against retirements in which no tag or exactly one tag differs. This catches a design that:
- compares unselected tags;
- ORs the comparisons instead of ANDing them;
- fires when nothing is selected.

Occurrence counts 0 through 5 are run with mismatching retirements placed between the matches, and the live count is read after each one. This exposes an off-by-one fire point, decrements on mismatches, and a counter that wraps past zero. Halt and event timing is checked one cycle after the fire and beyond, including release by clearing the flag or the enable. Reserved bits are written with all ones to show they stay 0.

// File: rtl/ibp_pkg.sv
package ibp_pkg;

  // Register byte offsets
  localparam int unsigned OFF_CTRL  = 0;
  localparam int unsigned OFF_CNT   = 4;
  localparam int unsigned OFF_CADDR = 8;
  localparam int unsigned OFF_CCTX  = 12;
  localparam int unsigned OFF_CVMID = 16;
  localparam int unsigned OFF_CPST  = 20;

  // Control word bit positions
  localparam int unsigned B_EN    = 0;
  localparam int unsigned B_HALT  = 1;
  localparam int unsigned B_EVT   = 2;
  localparam int unsigned B_FLAG  = 3;
  localparam int unsigned B_SADDR = 5;
  localparam int unsigned B_SCTX  = 7;
  localparam int unsigned B_SVMID = 8;
  localparam int unsigned B_SPST  = 9;
  localparam int unsigned B_CSUP  = 11;

  typedef struct packed {
    logic sel_pst;
    logic sel_vmid;
    logic sel_ctx;
    logic sel_addr;
    logic flag;
    logic evt_en;
    logic halt_en;
    logic en;
  } ibp_ctrl_t;

endpackage

// File: rtl/ibp_regs.sv
module ibp_regs
  import ibp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CTX_W  = 8,
  parameter int unsigned VMID_W = 8,
  parameter int unsigned PST_W  = 2,
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned BUS_AW = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              trig_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output ibp_ctrl_t         ctrl_o,
  output logic [ADDR_W-1:0] cmp_addr_o,
  output logic [CTX_W-1:0]  cmp_ctx_o,
  output logic [VMID_W-1:0] cmp_vmid_o,
  output logic [PST_W-1:0]  cmp_pst_o,
  output logic              cnt_we_o,
  output logic [CNT_W-1:0]  cnt_wdata_o
);

  localparam logic [BUS_AW-1:0] A_CTRL  = BUS_AW'(OFF_CTRL);
  localparam logic [BUS_AW-1:0] A_CNT   = BUS_AW'(OFF_CNT);
  localparam logic [BUS_AW-1:0] A_CADDR = BUS_AW'(OFF_CADDR);
  localparam logic [BUS_AW-1:0] A_CCTX  = BUS_AW'(OFF_CCTX);
  localparam logic [BUS_AW-1:0] A_CVMID = BUS_AW'(OFF_CVMID);
  localparam logic [BUS_AW-1:0] A_CPST  = BUS_AW'(OFF_CPST);

  logic wr_any, rd_any;
  logic ctrl_we, caddr_we, cctx_we, cvmid_we, cpst_we;
  logic ctrl_ld;

  ibp_ctrl_t         ctrl_q, ctrl_d;
  logic [ADDR_W-1:0] caddr_q;
  logic [CTX_W-1:0]  cctx_q;
  logic [VMID_W-1:0] cvmid_q;
  logic [PST_W-1:0]  cpst_q;
  logic [DATA_W-1:0] ctrl_word;

  assign wr_any   = bus_sel & bus_wr;
  assign rd_any   = bus_sel & ~bus_wr;
  assign ctrl_we  = wr_any & (bus_addr == A_CTRL);
  assign cnt_we_o = wr_any & (bus_addr == A_CNT);
  assign caddr_we = wr_any & (bus_addr == A_CADDR);
  assign cctx_we  = wr_any & (bus_addr == A_CCTX);
  assign cvmid_we = wr_any & (bus_addr == A_CVMID);
  assign cpst_we  = wr_any & (bus_addr == A_CPST);
  assign ctrl_ld  = ctrl_we | trig_i;

  assign cnt_wdata_o = bus_wdata[CNT_W-1:0];

  // Control next state: hardware set of the flag wins over a write
  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) begin
      ctrl_d.en       = bus_wdata[B_EN];
      ctrl_d.halt_en  = bus_wdata[B_HALT];
      ctrl_d.evt_en   = bus_wdata[B_EVT];
      ctrl_d.flag     = bus_wdata[B_FLAG];
      ctrl_d.sel_addr = bus_wdata[B_SADDR];
      ctrl_d.sel_ctx  = bus_wdata[B_SCTX];
      ctrl_d.sel_vmid = bus_wdata[B_SVMID];
      ctrl_d.sel_pst  = bus_wdata[B_SPST];
    end
    if (trig_i) begin
      ctrl_d.flag = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      caddr_q <= '0;
      cctx_q  <= '0;
      cvmid_q <= '0;
      cpst_q  <= '0;
    end else begin
      if (ctrl_ld)  ctrl_q  <= ctrl_d;
      if (caddr_we) caddr_q <= bus_wdata[ADDR_W-1:0];
      if (cctx_we)  cctx_q  <= bus_wdata[CTX_W-1:0];
      if (cvmid_we) cvmid_q <= bus_wdata[VMID_W-1:0];
      if (cpst_we)  cpst_q  <= bus_wdata[PST_W-1:0];
    end
  end

  always_comb begin
    ctrl_word          = '0;
    ctrl_word[B_EN]    = ctrl_q.en;
    ctrl_word[B_HALT]  = ctrl_q.halt_en;
    ctrl_word[B_EVT]   = ctrl_q.evt_en;
    ctrl_word[B_FLAG]  = ctrl_q.flag;
    ctrl_word[B_SADDR] = ctrl_q.sel_addr;
    ctrl_word[B_SCTX]  = ctrl_q.sel_ctx;
    ctrl_word[B_SVMID] = ctrl_q.sel_vmid;
    ctrl_word[B_SPST]  = ctrl_q.sel_pst;
    ctrl_word[B_CSUP]  = 1'b1;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_any) begin
      case (bus_addr)
        A_CTRL:  bus_rdata = ctrl_word;
        A_CNT:   bus_rdata = DATA_W'(cnt_i);
        A_CADDR: bus_rdata = DATA_W'(caddr_q);
        A_CCTX:  bus_rdata = DATA_W'(cctx_q);
        A_CVMID: bus_rdata = DATA_W'(cvmid_q);
        A_CPST:  bus_rdata = DATA_W'(cpst_q);
        default: bus_rdata = '0;
      endcase
    end
  end

  assign ctrl_o     = ctrl_q;
  assign cmp_addr_o = caddr_q;
  assign cmp_ctx_o  = cctx_q;
  assign cmp_vmid_o = cvmid_q;
  assign cmp_pst_o  = cpst_q;

  // R6: the flag is set by a fire and held until a control write
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> ctrl_q.flag);
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.flag && !ctrl_we) |=> ctrl_q.flag);

endmodule

// File: rtl/ibp_compare.sv
module ibp_compare
  import ibp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CTX_W  = 8,
  parameter int unsigned VMID_W = 8,
  parameter int unsigned PST_W  = 2
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CTX_W-1:0]  ctx_i,
  input  logic [VMID_W-1:0] vmid_i,
  input  logic [PST_W-1:0]  pst_i,
  input  ibp_ctrl_t         ctrl_i,
  input  logic [ADDR_W-1:0] cmp_addr_i,
  input  logic [CTX_W-1:0]  cmp_ctx_i,
  input  logic [VMID_W-1:0] cmp_vmid_i,
  input  logic [PST_W-1:0]  cmp_pst_i,
  output logic              qualify_o
);

  localparam int unsigned N_CRIT = 4;

  logic [N_CRIT-1:0] eq;
  logic [N_CRIT-1:0] sel;
  logic              all_hit;

  assign eq[0] = (addr_i == cmp_addr_i);
  assign eq[1] = (ctx_i  == cmp_ctx_i);
  assign eq[2] = (vmid_i == cmp_vmid_i);
  assign eq[3] = (pst_i  == cmp_pst_i);

  assign sel = {ctrl_i.sel_pst, ctrl_i.sel_vmid, ctrl_i.sel_ctx, ctrl_i.sel_addr};

  // An unselected criterion is a don't-care
  assign all_hit   = &(eq | ~sel);
  assign qualify_o = valid_i & ctrl_i.en & (|sel) & all_hit;

endmodule

// File: rtl/ibp_counter.sv
module ibp_counter #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qualify_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             trig_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_zero;
  logic             dec;
  logic             cnt_ld;

  assign at_zero = (cnt_q == '0);
  assign dec     = qualify_i & ~at_zero;
  assign cnt_ld  = we_i | dec;
  assign trig_o  = qualify_i & at_zero;

  // A software write takes priority over a decrement in the same cycle
  always_comb begin
    cnt_d = cnt_q;
    if (we_i)     cnt_d = wdata_i;
    else if (dec) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ld) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R4: each match above zero removes exactly one occurrence
  p_cnt_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (qualify_i && cnt_q != '0 && !we_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R4: a fire leaves the count at zero
  p_cnt_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_o && !we_i) |=> (cnt_q == '0));
  // R2: nothing but a write or a qualifying match moves the count
  p_cnt_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!qualify_i && !we_i) |=> $stable(cnt_q));

endmodule

// File: rtl/ibp_match_unit.sv
module ibp_match_unit
  import ibp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CTX_W  = 8,
  parameter int unsigned VMID_W = 8,
  parameter int unsigned PST_W  = 2,
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned BUS_AW = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              iv_valid,
  input  logic [ADDR_W-1:0] iv_addr,
  input  logic [CTX_W-1:0]  iv_ctx,
  input  logic [VMID_W-1:0] iv_vmid,
  input  logic [PST_W-1:0]  iv_pst,
  output logic              halt_req,
  output logic              evt_pulse
);

  ibp_ctrl_t         ctrl;
  logic [ADDR_W-1:0] cmp_addr;
  logic [CTX_W-1:0]  cmp_ctx;
  logic [VMID_W-1:0] cmp_vmid;
  logic [PST_W-1:0]  cmp_pst;
  logic              cnt_we;
  logic [CNT_W-1:0]  cnt_wdata;
  logic [CNT_W-1:0]  cnt;
  logic              qualify;
  logic              trig;
  logic              evt_q, evt_d;

  ibp_regs #(
    .ADDR_W(ADDR_W), .CTX_W(CTX_W), .VMID_W(VMID_W), .PST_W(PST_W),
    .CNT_W(CNT_W), .BUS_AW(BUS_AW), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .trig_i(trig), .cnt_i(cnt), .ctrl_o(ctrl),
    .cmp_addr_o(cmp_addr), .cmp_ctx_o(cmp_ctx),
    .cmp_vmid_o(cmp_vmid), .cmp_pst_o(cmp_pst),
    .cnt_we_o(cnt_we), .cnt_wdata_o(cnt_wdata)
  );

  ibp_compare #(
    .ADDR_W(ADDR_W), .CTX_W(CTX_W), .VMID_W(VMID_W), .PST_W(PST_W)
  ) u_cmp (
    .valid_i(iv_valid), .addr_i(iv_addr), .ctx_i(iv_ctx),
    .vmid_i(iv_vmid), .pst_i(iv_pst), .ctrl_i(ctrl),
    .cmp_addr_i(cmp_addr), .cmp_ctx_i(cmp_ctx),
    .cmp_vmid_i(cmp_vmid), .cmp_pst_i(cmp_pst),
    .qualify_o(qualify)
  );

  ibp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .qualify_i(qualify), .we_i(cnt_we), .wdata_i(cnt_wdata),
    .cnt_o(cnt), .trig_o(trig)
  );

  assign evt_d = trig & ctrl.evt_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= evt_d;
  end

  assign evt_pulse = evt_q;
  assign halt_req  = ctrl.flag & ctrl.halt_en & ctrl.en;

  // R2: no fire while disabled
  p_dis_no_trig_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |-> !trig);
  // R3: with no criterion selected nothing fires
  p_nocrit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl.sel_addr | ctrl.sel_ctx | ctrl.sel_vmid | ctrl.sel_pst) |-> !trig);
  // R8: an event pulse always comes with the flag
  p_evt_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> ctrl.flag);

endmodule

// File: tb/ibp_match_unit_test.sv
module ibp_match_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        iv_valid = 1'b0;
  logic [31:0] iv_addr = '0;
  logic [7:0]  iv_ctx = '0;
  logic [7:0]  iv_vmid = '0;
  logic [1:0]  iv_pst = '0;
  logic        halt_req;
  logic        evt_pulse;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [31:0] CA = 32'h0000_1F40;
  localparam logic [7:0]  CC = 8'h5A;
  localparam logic [7:0]  CV = 8'h3C;
  localparam logic [1:0]  CP = 2'b10;

  always #5 clk = ~clk;

  ibp_match_unit uut (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .iv_valid(iv_valid), .iv_addr(iv_addr), .iv_ctx(iv_ctx),
    .iv_vmid(iv_vmid), .iv_pst(iv_pst),
    .halt_req(halt_req), .evt_pulse(evt_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  // One retirement; returns evt_pulse in the cycle after it
  task automatic instr(input logic [31:0] a, input logic [7:0] c, input logic [7:0] v,
                       input logic [1:0] p, output logic ev);
    @(negedge clk);
    iv_valid = 1'b1; iv_addr = a; iv_ctx = c; iv_vmid = v; iv_pst = p;
    @(negedge clk);
    iv_valid = 1'b0;
    ev = evt_pulse;
  endtask

  function automatic logic [31:0] ctrl_w(input bit en, input bit hl, input bit ev,
                                          input bit fl, input logic [3:0] sel);
    logic [31:0] w;
    w = '0;
    w[0] = en; w[1] = hl; w[2] = ev; w[3] = fl;
    w[5] = sel[0]; w[7] = sel[1]; w[8] = sel[2]; w[9] = sel[3];
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic ev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 halt", {31'b0, halt_req}, 0);
    chk("R1 evt", {31'b0, evt_pulse}, 0);
    rd(5'd0, r);  chk("R1 ctrl", r, 32'h800);
    rd(5'd4, r);  chk("R1 count", r, 0);
    rd(5'd8, r);  chk("R1 caddr", r, 0);
    rd(5'd20, r); chk("R1 cpst", r, 0);

    // R9: reserved bits
    wr(5'd0, 32'hFFFF_FFFF);
    rd(5'd0, r); chk("R9 ctrl all ones", r, 32'hBAF);
    wr(5'd0, 32'h0);
    rd(5'd0, r); chk("R9 ctrl zero", r, 32'h800);
    wr(5'd4, 32'hFFFF_FFFF);
    rd(5'd4, r); chk("R9 count width", r, 32'h000F_FFFF);
    wr(5'd24, 32'hFFFF_FFFF);
    rd(5'd24, r); chk("R9 unmapped", r, 0);

    // R10: comparison registers
    wr(5'd8, 32'hDEAD_BEEF);  rd(5'd8, r);  chk("R10 caddr", r, 32'hDEAD_BEEF);
    wr(5'd12, 32'hFFFF_FFA5); rd(5'd12, r); chk("R10 cctx", r, 32'hA5);
    wr(5'd16, 32'h1234_5677); rd(5'd16, r); chk("R10 cvmid", r, 32'h77);
    wr(5'd20, 32'hFFFF_FFFF); rd(5'd20, r); chk("R10 cpst", r, 32'h3);

    wr(5'd8, CA); wr(5'd12, {24'b0, CC}); wr(5'd16, {24'b0, CV}); wr(5'd20, {30'b0, CP});

    // R2: disabled unit ignores matches
    wr(5'd4, 32'd2);
    wr(5'd0, ctrl_w(0, 1, 1, 0, 4'b0001));
    for (int k = 0; k < 3; k++) begin
      instr(CA, CC, CV, CP, ev);
      chk("R2 no evt when disabled", {31'b0, ev}, 0);
    end
    rd(5'd4, r); chk("R2 count held", r, 2);
    rd(5'd0, r); chk("R2 flag clear", r, ctrl_w(0, 1, 1, 0, 4'b0001) | 32'h800);
    chk("R2 no halt", {31'b0, halt_req}, 0);

    // R3: sweep of selects against single-field mismatches
    for (int sel = 0; sel < 16; sel++) begin
      for (int pat = 0; pat < 5; pat++) begin
        logic [31:0] a; logic [7:0] c; logic [7:0] v; logic [1:0] p;
        bit exp;
        a = CA; c = CC; v = CV; p = CP;
        if (pat == 1) a = CA ^ 32'h4;
        if (pat == 2) c = CC ^ 8'h01;
        if (pat == 3) v = CV ^ 8'h80;
        if (pat == 4) p = CP ^ 2'b01;
        exp = (sel != 0) && !(pat != 0 && sel[pat-1]);
        wr(5'd4, 32'd0);
        wr(5'd0, ctrl_w(1, 0, 1, 0, sel[3:0]));
        instr(a, c, v, p, ev);
        chk("R3 select sweep evt", {31'b0, ev}, {31'b0, exp});
        rd(5'd0, r);
        chk("R3 select sweep flag", {31'b0, r[3]}, {31'b0, exp});
      end
    end

    // R4/R5: occurrence counts with interleaved mismatches
    for (int n = 0; n < 6; n++) begin
      wr(5'd0, ctrl_w(1, 0, 1, 0, 4'b0011));
      wr(5'd4, n);
      for (int k = 1; k <= n + 1; k++) begin
        instr(CA, CC ^ 8'hFF, CV, CP, ev);
        chk("R4 mismatch no evt", {31'b0, ev}, 0);
        rd(5'd4, r); chk("R4 mismatch keeps count", r, n - k + 1);
        instr(CA, CC, CV, CP, ev);
        chk("R4 fire on n+1", {31'b0, ev}, {31'b0, (k == n + 1)});
        rd(5'd4, r); chk("R5 live count", r, (k <= n) ? (n - k) : 0);
      end
      instr(CA, CC, CV, CP, ev);
      chk("R4 refire at zero", {31'b0, ev}, 1);
      rd(5'd4, r); chk("R4 stays zero", r, 0);
    end

    // R8: pulse is one cycle; no pulse with event off
    wr(5'd0, ctrl_w(1, 0, 1, 0, 4'b0001));
    instr(CA, 8'h00, 8'h00, 2'b00, ev);
    chk("R8 pulse", {31'b0, ev}, 1);
    @(negedge clk);
    chk("R8 pulse one cycle", {31'b0, evt_pulse}, 0);
    wr(5'd0, ctrl_w(1, 0, 0, 0, 4'b0001));
    instr(CA, CC, CV, CP, ev);
    chk("R8 no pulse when off", {31'b0, ev}, 0);
    rd(5'd0, r); chk("R8 flag set anyway", {31'b0, r[3]}, 1);

    // R6/R7: sticky flag and halt
    wr(5'd0, ctrl_w(1, 1, 0, 0, 4'b1000));
    chk("R7 halt low before fire", {31'b0, halt_req}, 0);
    instr(32'h0, 8'h0, 8'h0, CP, ev);
    chk("R7 halt after fire", {31'b0, halt_req}, 1);
    repeat (4) @(negedge clk);
    chk("R7 halt held", {31'b0, halt_req}, 1);
    wr(5'd4, 32'd7);
    rd(5'd0, r); chk("R6 flag sticky", {31'b0, r[3]}, 1);
    wr(5'd0, ctrl_w(1, 1, 0, 0, 4'b1000));
    chk("R7 halt released by flag clear", {31'b0, halt_req}, 0);
    rd(5'd0, r); chk("R6 flag cleared", {31'b0, r[3]}, 0);
    wr(5'd4, 32'd0);
    instr(32'h0, 8'h0, 8'h0, CP, ev);
    chk("R7 halt again", {31'b0, halt_req}, 1);
    wr(5'd0, ctrl_w(0, 1, 0, 1, 4'b1000));
    chk("R7 halt released by enable", {31'b0, halt_req}, 0);
    rd(5'd0, r); chk("R6 flag kept", {31'b0, r[3]}, 1);
    wr(5'd0, ctrl_w(1, 1, 0, 1, 4'b1000));
    chk("R7 halt returns with enable", {31'b0, halt_req}, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule